// File: doc/BRIEF.md
# Cascaded Sigma-Delta Recombination and Mode Control

This block is the digital back end of a 2-2 cascaded sigma-delta converter that can be reconfigured at run time. It holds one mode configuration: the noise-shaping order, the sampling-rate code, the bandwidth code and the bias-current code. From the active order it drives the enables of the two analog stages and the three input routing selectors. The rate, bandwidth and bias codes leave the block unchanged for the analog and clocking logic.

In fourth-order mode, the single-bit streams of both stages go through a recombination filter. The filter delays the first-stage stream by two samples and second-differences the second-stage stream, so that the first-stage quantization error cancels in the sum. In second-order mode, the first stage is switched off, the analog input is routed straight to the second stage, and that stage's bit passes through as a plus-or-minus-one word.

Software writes a mode word through a one-cycle write strobe. The block holds the word as pending and applies it on the next sample strobe. A change of mode clears the filter history, and the output stays flagged invalid until the history has refilled.

Top module: `mash_recomb_top`

## Requirements
- R1: After reset the active mode is the standard preset: fourth order, rate code 1, bandwidth code 1, bias code 1. The output word is 0 and the valid flag is low.
- R2: The mode word is laid out as follows. Bit 0 is the order (1 means fourth). Bits 2:1 are the rate code (0, 1, 2 for 768 kHz, 2.4 MHz, 3.6 MHz). Bit 3 is the bandwidth (0 means 4 kHz, 1 means 20 kHz). Bits 5:4 are the bias code (0, 1, 2 for 50 %, 75 %, 100 %). Bits 7:6 select a preset. Value 0 uses the fields. Value 1 is low power (second order, rate 0, bandwidth 0, bias 0). Value 2 is standard (fourth order, rate 1, bandwidth 1, bias 1). Value 3 is high resolution (fourth order, rate 2, bandwidth 1, bias 2).
- R3: A write whose preset select is 0 and whose rate code or bias code is 3 is ignored. It leaves both the pending mode and the active mode unchanged.
- R4: A written mode becomes active only at the next sample strobe. Until then every mode output keeps its previous value.
- R5: In fourth-order mode both stage enables are high. The input is routed to stage one, stage one feeds stage two, and the direct input-to-stage-two route is off.
- R6: In second-order mode the stage-one enable is low and the stage-two enable is high. The input is routed only to stage two, and the stage-one-to-stage-two route is off.
- R7: In fourth-order mode, each sample strobe maps every bit to +1 (bit 1) or -1 (bit 0). The output is then registered as y1[n-2] + y2[n] - 2·y2[n-1] + y2[n-2], a signed 4-bit value within -5..+5.
- R8: When the second-stage stream is constant, the valid output equals the first-stage value of two samples earlier.
- R9: In second-order mode, each sample strobe registers +1 or -1 from the second-stage bit alone.
- R10: A sample strobe that activates a different mode consumes no bits. It zeroes the history and the output, and it drives valid low. The next three samples are invalid, and the fourth is valid. The same three-sample window follows reset.
- R11: Rewriting the mode that is already active leaves the history and the valid flag undisturbed.
- R12: The output word and the valid flag change only on a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode word write strobe |
| cfg_wdata_i | input | 8 | Mode word |
| smp_i | input | 1 | Sample strobe, one per modulator sample |
| s1_bit_i | input | 1 | Stage-one output bit |
| s2_bit_i | input | 1 | Stage-two output bit |
| s1_en_o | output | 1 | Stage-one enable |
| s2_en_o | output | 1 | Stage-two enable |
| in_to_s1_o | output | 1 | Route analog input to stage one |
| s1_to_s2_o | output | 1 | Route stage-one integrator output to stage two |
| in_to_s2_o | output | 1 | Route analog input directly to stage two |
| rate_sel_o | output | 2 | Active sampling-rate code |
| bw_sel_o | output | 1 | Active bandwidth code |
| bias_sel_o | output | 2 | Active bias-current code |
| dout_o | output | 4 | Signed output word |
| dout_vld_o | output | 1 | Output valid |

## Verification
The bench builds the block with its defaults: a 4-bit output and a three-sample settle window. With these values the full ±5 range of the recombined word and the exact invalid window after every mode change can be observed at the ports. Sample strobes come every few clocks, so the bench can also check that the output holds between strobes and that a pending mode does not show before the boundary. Random bit streams and random mode words, reserved codes included, are mixed with directed preset switches, a rewrite of the active mode, and a constant second-stage stream that exposes the cancellation.

// File: rtl/mash_pkg.sv
package mash_pkg;

  localparam int WORD_W = 8;

  typedef struct packed {
    logic       ord4;
    logic [1:0] rate;
    logic       bw20;
    logic [1:0] bias;
  } mode_t;

  localparam mode_t MODE_LP = '{ord4: 1'b0, rate: 2'd0, bw20: 1'b0, bias: 2'd0};
  localparam mode_t MODE_ST = '{ord4: 1'b1, rate: 2'd1, bw20: 1'b1, bias: 2'd1};
  localparam mode_t MODE_HR = '{ord4: 1'b1, rate: 2'd2, bw20: 1'b1, bias: 2'd2};

  typedef enum logic [1:0] {
    SEL_CUSTOM = 2'd0,
    SEL_LP     = 2'd1,
    SEL_ST     = 2'd2,
    SEL_HR     = 2'd3
  } preset_e;

  function automatic logic word_ok(input logic [WORD_W-1:0] w);
    return (w[7:6] != SEL_CUSTOM) || ((w[2:1] != 2'd3) && (w[5:4] != 2'd3));
  endfunction

  function automatic mode_t word_decode(input logic [WORD_W-1:0] w);
    mode_t m;
    unique case (preset_e'(w[7:6]))
      SEL_LP:  m = MODE_LP;
      SEL_ST:  m = MODE_ST;
      SEL_HR:  m = MODE_HR;
      default: m = '{ord4: w[0], rate: w[2:1], bw20: w[3], bias: w[5:4]};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mash_cfg.sv
module mash_cfg
  import mash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              smp_i,
  output mode_t             mode_o,
  output logic              apply_o
);

  mode_t pend_q, act_q;
  logic  pend_v_q;
  logic  wr_ok;

  assign wr_ok   = we_i & word_ok(wdata_i);
  assign apply_o = smp_i & pend_v_q & (pend_q != act_q);
  assign mode_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= MODE_ST;
      pend_q   <= MODE_ST;
      pend_v_q <= 1'b0;
    end else begin
      if (smp_i && pend_v_q) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (wr_ok) begin
        pend_q   <= word_decode(wdata_i);
        pend_v_q <= 1'b1;
      end
    end
  end

  // R4
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> $stable(act_q));

  // R3
  bad_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !word_ok(wdata_i) && !smp_i) |=> ($stable(pend_q) && $stable(pend_v_q)));

endmodule

// File: rtl/mash_route.sv
module mash_route
  import mash_pkg::*;
(
  input  mode_t      mode_i,
  output logic       s1_en_o,
  output logic       s2_en_o,
  output logic       in_to_s1_o,
  output logic       s1_to_s2_o,
  output logic       in_to_s2_o,
  output logic [1:0] rate_o,
  output logic       bw_o,
  output logic [1:0] bias_o
);

  always_comb begin
    s2_en_o    = 1'b1;
    s1_en_o    = mode_i.ord4;
    in_to_s1_o = mode_i.ord4;
    s1_to_s2_o = mode_i.ord4;
    in_to_s2_o = ~mode_i.ord4;
    rate_o     = mode_i.rate;
    bw_o       = mode_i.bw20;
    bias_o     = mode_i.bias;
  end

endmodule

// File: rtl/mash_recomb.sv
module mash_recomb #(
  parameter int OUT_W  = 4,
  parameter int SETTLE = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_i,
  input  logic                    apply_i,
  input  logic                    ord4_i,
  input  logic                    b1_i,
  input  logic                    b2_i,
  output logic signed [OUT_W-1:0] out_o,
  output logic                    vld_o
);

  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic signed [OUT_W-1:0] POS  = OUT_W'(1);
  localparam logic signed [OUT_W-1:0] NEG  = -POS;
  localparam logic signed [OUT_W-1:0] MAXV = OUT_W'(5);

  logic signed [OUT_W-1:0] y1, y2, sum4;
  logic signed [OUT_W-1:0] y1_d1, y1_d2, y2_d1, y2_d2;
  logic [CNT_W-1:0]        cnt_q;

  assign y1   = b1_i ? POS : NEG;
  assign y2   = b2_i ? POS : NEG;
  // z^-2 y1 + (1 - z^-1)^2 y2
  assign sum4 = y1_d2 + y2 - (y2_d1 <<< 1) + y2_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_d1 <= '0;
      y1_d2 <= '0;
      y2_d1 <= '0;
      y2_d2 <= '0;
      out_o <= '0;
      vld_o <= 1'b0;
      cnt_q <= CNT_W'(SETTLE);
    end else if (apply_i) begin
      y1_d1 <= '0;
      y1_d2 <= '0;
      y2_d1 <= '0;
      y2_d2 <= '0;
      out_o <= '0;
      vld_o <= 1'b0;
      cnt_q <= CNT_W'(SETTLE);
    end else if (smp_i) begin
      y1_d1 <= y1;
      y1_d2 <= y1_d1;
      y2_d1 <= y2;
      y2_d2 <= y2_d1;
      out_o <= ord4_i ? sum4 : y2;
      vld_o <= (cnt_q == '0);
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7
  out_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o <= MAXV) && (out_o >= -MAXV));

  // R9
  bypass_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !ord4_i) |-> ((out_o == POS) || (out_o == NEG)));

  // R10
  change_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (!vld_o && (out_o == '0)));

  // R12
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> ($stable(out_o) && $stable(vld_o)));

endmodule

// File: rtl/mash_recomb_top.sv
module mash_recomb_top
  import mash_pkg::*;
#(
  parameter int OUT_W  = 4,
  parameter int SETTLE = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [7:0]              cfg_wdata_i,
  input  logic                    smp_i,
  input  logic                    s1_bit_i,
  input  logic                    s2_bit_i,
  output logic                    s1_en_o,
  output logic                    s2_en_o,
  output logic                    in_to_s1_o,
  output logic                    s1_to_s2_o,
  output logic                    in_to_s2_o,
  output logic [1:0]              rate_sel_o,
  output logic                    bw_sel_o,
  output logic [1:0]              bias_sel_o,
  output logic signed [OUT_W-1:0] dout_o,
  output logic                    dout_vld_o
);

  mode_t mode;
  logic  apply;

  mash_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .smp_i   (smp_i),
    .mode_o  (mode),
    .apply_o (apply)
  );

  mash_route u_route (
    .mode_i     (mode),
    .s1_en_o    (s1_en_o),
    .s2_en_o    (s2_en_o),
    .in_to_s1_o (in_to_s1_o),
    .s1_to_s2_o (s1_to_s2_o),
    .in_to_s2_o (in_to_s2_o),
    .rate_o     (rate_sel_o),
    .bw_o       (bw_sel_o),
    .bias_o     (bias_sel_o)
  );

  mash_recomb #(.OUT_W(OUT_W), .SETTLE(SETTLE)) u_recomb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (smp_i),
    .apply_i (apply),
    .ord4_i  (mode.ord4),
    .b1_i    (s1_bit_i),
    .b2_i    (s2_bit_i),
    .out_o   (dout_o),
    .vld_o   (dout_vld_o)
  );

  // R5
  ord4_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_en_o |-> (s2_en_o && in_to_s1_o && s1_to_s2_o && !in_to_s2_o));

  // R6
  ord2_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_en_o |-> (s2_en_o && in_to_s2_o && !in_to_s1_o && !s1_to_s2_o));

endmodule

// File: tb/mash_recomb_top_tb.sv
`timescale 1ns/1ps
module mash_recomb_top_tb;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, smp = 1'b0, b1 = 1'b0, b2 = 1'b0;
  logic [7:0] wdata = '0;
  logic s1_en, s2_en, in_s1, s1_s2, in_s2, bw;
  logic [1:0] rate, bias;
  logic signed [3:0] dout;
  logic dvld;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model: mode bits {ord4, rate[1:0], bw, bias[1:0]}
  logic [5:0] act, pend;
  bit pv;
  int h1d1, h1d2, h2d1, h2d2, cnt, eout;
  bit evld;

  always #4 clk = ~clk;

  mash_recomb_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(wdata),
    .smp_i(smp), .s1_bit_i(b1), .s2_bit_i(b2),
    .s1_en_o(s1_en), .s2_en_o(s2_en), .in_to_s1_o(in_s1), .s1_to_s2_o(s1_s2),
    .in_to_s2_o(in_s2), .rate_sel_o(rate), .bw_sel_o(bw), .bias_sel_o(bias),
    .dout_o(dout), .dout_vld_o(dvld)
  );

  function automatic bit w_ok(input logic [7:0] w);
    return (w[7:6] != 0) || ((w[2:1] != 3) && (w[5:4] != 3));
  endfunction

  function automatic logic [5:0] w_dec(input logic [7:0] w);
    case (w[7:6])
      2'd1: return 6'b0_00_0_00;
      2'd2: return 6'b1_01_1_01;
      2'd3: return 6'b1_10_1_10;
      default: return {w[0], w[2:1], w[3], w[5:4]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic chk_route(input string req);
    logic [9:0] got, exp;
    got = {s1_en, s2_en, in_s1, s1_s2, in_s2, rate, bw, bias};
    exp = {act[5], 1'b1, act[5], act[5], ~act[5], act[4:3], act[2], act[1:0]};
    chk(got == exp, req, int'(got), int'(exp));
  endtask

  task automatic chk_out(input string req);
    chk(int'(dout) == eout, req, int'(dout), eout);
    chk(dvld == evld, req, int'(dvld), int'(evld));
  endtask

  task automatic cfg_write(input logic [7:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    wdata  = w;
    @(posedge clk);
    if (w_ok(w)) begin
      pend = w_dec(w);
      pv   = 1'b1;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model_sample(input bit x1, input bit x2);
    int y1, y2;
    if (pv) begin
      pv = 1'b0;
      if (pend != act) begin
        act = pend;
        h1d1 = 0; h1d2 = 0; h2d1 = 0; h2d2 = 0;
        eout = 0; evld = 1'b0; cnt = 3;
        return;
      end
    end
    y1 = x1 ? 1 : -1;
    y2 = x2 ? 1 : -1;
    eout = act[5] ? (h1d2 + y2 - 2 * h2d1 + h2d2) : y2;
    evld = (cnt == 0);
    if (cnt > 0) cnt--;
    h1d2 = h1d1; h1d1 = y1;
    h2d2 = h2d1; h2d1 = y2;
  endtask

  task automatic sample(input bit x1, input bit x2, input string req);
    @(negedge clk);
    smp = 1'b1; b1 = x1; b2 = x2;
    @(posedge clk);
    model_sample(x1, x2);
    @(negedge clk);
    smp = 1'b0;
    chk_out(req);
    chk_route(act[5] ? "R5" : "R6");
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p1, p2, sv;
    logic signed [3:0] held;
    void'($urandom(32'd20240917));
    act = 6'b1_01_1_01; pend = act; pv = 1'b0;
    h1d1 = 0; h1d2 = 0; h2d1 = 0; h2d2 = 0; cnt = 3; eout = 0; evld = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_route("R1");
    chk_out("R1");

    // R7 fourth-order recombination, random streams, incl. settle after reset
    for (int i = 0; i < 40; i++) sample($urandom_range(0, 1), $urandom_range(0, 1), "R7");
    // R7 extremes: +5 and -5
    sample(1, 0, "R7"); sample(1, 1, "R7"); sample(1, 0, "R7"); sample(1, 1, "R7");
    sample(0, 1, "R7"); sample(0, 0, "R7"); sample(0, 1, "R7"); sample(0, 0, "R7");

    // R4 pending mode not visible before boundary
    cfg_write(8'h40);
    repeat (3) @(negedge clk);
    chk_route("R4");
    // R10 change: no bits consumed, cleared, invalid window
    sample(1, 1, "R10");
    chk(act == 6'b0_00_0_00, "R2", int'(act), 0);
    chk_route("R2");
    for (int i = 0; i < 4; i++) sample($urandom_range(0, 1), $urandom_range(0, 1), "R10");
    // R9 second-order bypass
    for (int i = 0; i < 20; i++) sample($urandom_range(0, 1), $urandom_range(0, 1), "R9");

    // R3 reserved codes ignored
    cfg_write(8'h1F);
    sample(0, 1, "R3");
    chk_route("R3");
    cfg_write(8'h31);
    sample(1, 0, "R3");
    chk_route("R3");

    // R2 custom fields: ord4, rate 1, bw 0, bias 1
    cfg_write(8'h13);
    sample(0, 0, "R10");
    chk_route("R2");
    // R10 first sample after change uses cleared history
    sample(1, 0, "R10");
    sample(0, 1, "R10");
    sample(1, 1, "R10");

    // R8 constant stage-two stream: output is stage one delayed by two
    p1 = 0; p2 = 0;
    for (int i = 0; i < 24; i++) begin
      sv = $urandom_range(0, 1);
      sample(sv[0], 1, "R7");
      if (dvld && i >= 2) chk(int'(dout) == p2, "R8", int'(dout), p2);
      p2 = p1; p1 = sv[0] ? 1 : -1;
    end

    // R11 rewrite of active mode
    cfg_write(8'h13);
    sample(1, 1, "R11");
    chk(dvld == 1'b1, "R11", int'(dvld), 1);

    // R12 hold between strobes
    held = dout;
    repeat (5) @(negedge clk);
    chk(dout == held, "R12", int'(dout), int'(held));

    // presets and random mix
    cfg_write(8'hC0);
    sample(0, 0, "R10");
    chk(act == 6'b1_10_1_10, "R2", int'(act), int'(6'b1_10_1_10));
    cfg_write(8'h80);
    sample(0, 0, "R10");
    chk(act == 6'b1_01_1_01, "R2", int'(act), int'(6'b1_01_1_01));
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) cfg_write(8'($urandom_range(0, 255)));
      else sample($urandom_range(0, 1), $urandom_range(0, 1), "R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule